// File: doc/BRIEF.md
# Quadrant Master-ID Access Gate

This block sits between a bus interconnect and a peripheral frame split into four address quadrants. Every access to the frame carries the identifier of the bus master that issued it. The gate keeps a permission mask for each quadrant, with one bit for each master. It takes the quadrant from the top of the frame offset and the bit from the master identifier. If that bit is set, the access goes on to the peripheral in the same cycle. If it is clear, the access never reaches the peripheral, and a bus error response comes back on the following cycle.

The four masks sit in two 32-bit configuration registers, two quadrants in each. Any access may read them back, user or privileged. Only a privileged write changes them. A user write is dropped silently. After reset every mask is zero, so every master is shut out of every quadrant until software grants access.

Top module: `qag_access_gate`

## Requirements
- R1: Each quadrant has a 16-bit mask, and bit n of it belongs to master ID n. An access is permitted exactly when the selected bit is 1. A permitted access raises `fwd_valid` in the same cycle, with `fwd_addr` equal to `acc_addr`.
- R2: Register select 0 holds quadrant 0 in bits 15:0 and quadrant 1 in bits 31:16. Register select 1 holds quadrant 2 in bits 15:0 and quadrant 3 in bits 31:16.
- R3: The quadrant is `acc_addr[ADDR_W-1:ADDR_W-2]`, read as an unsigned number 0 to 3. No other address bit affects the decision.
- R4: A denied access leaves `fwd_valid` low. `acc_err` is high in the cycle after each cycle that holds a denied request.
- R5: `acc_err` is low in the cycle after any cycle that has no request or only a permitted one.
- R6: `cfg_rdata` always shows the register picked by `cfg_sel`, whatever the value of `cfg_priv`.
- R7: A write with `cfg_priv` = 1 replaces the whole selected register: a 1 sets a bit and a 0 clears it. The new value takes effect from the next cycle. An access in the cycle of the write is judged with the old masks.
- R8: A write with `cfg_priv` = 0 changes no register and raises no `acc_err`.
- R9: Reset clears all masks to zero, so every access is denied until a privileged write grants it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access request from the interconnect |
| acc_addr | input | ADDR_W | Offset of the access within the frame |
| acc_mid | input | MID_W | Identifier of the requesting master |
| fwd_valid | output | 1 | Access passed on to the peripheral |
| fwd_addr | output | ADDR_W | Offset passed on to the peripheral |
| acc_err | output | 1 | Registered bus error for a denied access |
| cfg_sel | input | 1 | Register select: 0 = quadrants 0/1, 1 = quadrants 2/3 |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_priv | input | 1 | 1 = privileged access |
| cfg_wdata | input | 2*2**MID_W | Configuration write data |
| cfg_rdata | output | 2*2**MID_W | Contents of the selected register |

## Verification
Directed accesses from all 16 master IDs run against the two worked masks, alternating bits on quadrant 0 and bit pairs on quadrant 1. This pattern would expose a swapped bit order, a swapped half of a register, or a wrong quadrant decode. A second register, with distinct masks for quadrants 2 and 3, separates the two register selects. Writes and accesses in the same cycle show whether the gate judges an access with the old masks or the new ones. User writes filled with all ones show whether a write that should be dropped leaks into the masks or raises an error. Random traffic then mixes privileged and user writes, random masks, idle cycles and denied back-to-back requests. It tests that the error pulse tracks each individual request.

// File: rtl/qag_pkg.sv
package qag_pkg;
    localparam int QUADS     = 4;
    localparam int BANKS     = 2;
    localparam int QUAD_BITS = $clog2(QUADS);
    localparam int BANK_BITS = $clog2(BANKS);

    typedef logic [QUAD_BITS-1:0] quad_t;
endpackage

// File: rtl/qag_perm_regs.sv
module qag_perm_regs
    import qag_pkg::*;
#(
    parameter int MASK_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       wr_priv,
    input  logic [BANK_BITS-1:0]       sel,
    input  logic [2*MASK_W-1:0]        wdata,
    output logic [2*MASK_W-1:0]        rdata,
    output logic [QUADS*MASK_W-1:0]    masks
);
    localparam int BANK_W = 2 * MASK_W;

    typedef struct packed {
        logic [BANKS-1:0][BANK_W-1:0] bank;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en && wr_priv) begin
            regs_d.bank[sel] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rdata = regs_q.bank[sel];
    assign masks = regs_q.bank;
endmodule

// File: rtl/qag_lookup.sv
module qag_lookup
    import qag_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int MID_W  = 4
) (
    input  logic [ADDR_W-1:0]                addr,
    input  logic [MID_W-1:0]                 mid,
    input  logic [QUADS*(1<<MID_W)-1:0]      masks,
    output logic                             permit
);
    localparam int MASK_W = 1 << MID_W;

    quad_t             quad;
    logic [QUADS-1:0]  quad_hit;

    assign quad = addr[ADDR_W-1 -: QUAD_BITS];

    for (genvar q = 0; q < QUADS; q++) begin : g_quad
        logic [MASK_W-1:0] field;
        assign field       = masks[q*MASK_W +: MASK_W];
        assign quad_hit[q] = (quad == quad_t'(q)) && field[mid];
    end

    assign permit = |quad_hit;
endmodule

// File: rtl/qag_respond.sv
module qag_respond (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic permit,
    output logic fwd,
    output logic err
);
    typedef struct packed {
        logic err;
    } resp_t;

    resp_t resp_d, resp_q;

    always_comb begin
        resp_d     = resp_q;
        resp_d.err = req && !permit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign fwd = req && permit;
    assign err = resp_q.err;
endmodule

// File: rtl/qag_access_gate.sv
module qag_access_gate
    import qag_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int MID_W  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        acc_valid,
    input  logic [ADDR_W-1:0]           acc_addr,
    input  logic [MID_W-1:0]            acc_mid,
    output logic                        fwd_valid,
    output logic [ADDR_W-1:0]           fwd_addr,
    output logic                        acc_err,
    input  logic                        cfg_sel,
    input  logic                        cfg_wr,
    input  logic                        cfg_priv,
    input  logic [2*(1<<MID_W)-1:0]     cfg_wdata,
    output logic [2*(1<<MID_W)-1:0]     cfg_rdata
);
    localparam int MASK_W = 1 << MID_W;

    logic [QUADS*MASK_W-1:0] mask_flat;
    logic                    permit;

    qag_perm_regs #(.MASK_W(MASK_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_priv (cfg_priv),
        .sel     (cfg_sel),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .masks   (mask_flat)
    );

    qag_lookup #(.ADDR_W(ADDR_W), .MID_W(MID_W)) u_lookup (
        .addr   (acc_addr),
        .mid    (acc_mid),
        .masks  (mask_flat),
        .permit (permit)
    );

    qag_respond u_resp (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (acc_valid),
        .permit (permit),
        .fwd    (fwd_valid),
        .err    (acc_err)
    );

    assign fwd_addr = acc_addr;
endmodule

// File: rtl/qag_access_gate_chk.sv
module qag_access_gate_chk #(
    parameter int ADDR_W = 12,
    parameter int MID_W  = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      acc_valid,
    input logic [ADDR_W-1:0]         acc_addr,
    input logic [MID_W-1:0]          acc_mid,
    input logic                      fwd_valid,
    input logic                      acc_err,
    input logic                      cfg_wr,
    input logic                      cfg_priv,
    input logic [4*(1<<MID_W)-1:0]   masks
);
    logic granted;
    assign granted = masks[{acc_addr[ADDR_W-1 -: 2], acc_mid}];

    p_fwd_needs_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> (acc_valid && granted));

    p_grant_forwards_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && granted) |-> fwd_valid);

    p_deny_errors_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !granted) |=> acc_err);

    p_quiet_no_error_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !granted) |=> !acc_err);

    p_user_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_priv) |=> $stable(masks));

    p_reset_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (masks == '0));
endmodule

bind qag_access_gate qag_access_gate_chk #(.ADDR_W(ADDR_W), .MID_W(MID_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .acc_mid   (acc_mid),
    .fwd_valid (fwd_valid),
    .acc_err   (acc_err),
    .cfg_wr    (cfg_wr),
    .cfg_priv  (cfg_priv),
    .masks     (mask_flat)
);

// File: tb/qag_access_gate_test.sv
`timescale 1ns/1ps
module qag_access_gate_test;
    localparam int ADDR_W = 12;
    localparam int MID_W  = 4;
    localparam int W      = 2 * (1 << MID_W);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              acc_valid = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic [MID_W-1:0]  acc_mid = '0;
    logic              fwd_valid;
    logic [ADDR_W-1:0] fwd_addr;
    logic              acc_err;
    logic              cfg_sel = 1'b0;
    logic              cfg_wr = 1'b0;
    logic              cfg_priv = 1'b0;
    logic [W-1:0]      cfg_wdata = '0;
    logic [W-1:0]      cfg_rdata;

    int checks = 0;
    int fails  = 0;

    logic [W-1:0] model [2];
    logic         exp_err = 1'b0;

    always #2.5 clk = ~clk;

    qag_access_gate #(.ADDR_W(ADDR_W), .MID_W(MID_W)) uut (.*);

    function automatic logic allowed(logic [ADDR_W-1:0] a, logic [MID_W-1:0] m);
        int q = int'(a[ADDR_W-1:ADDR_W-2]);
        logic [W-1:0] r = model[q / 2];
        return r[(q % 2) * 16 + int'(m)];
    endfunction

    function automatic logic [ADDR_W-1:0] qaddr(int q, logic [ADDR_W-3:0] low);
        return {q[1:0], low};
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive, check at the falling edge, update the model at the rising edge.
    task automatic cycle(logic v, logic [ADDR_W-1:0] a, logic [MID_W-1:0] m,
                         logic wr, logic pr, logic sel, logic [W-1:0] wd, string req);
        logic p;
        acc_valid = v; acc_addr = a; acc_mid = m;
        cfg_wr = wr; cfg_priv = pr; cfg_sel = sel; cfg_wdata = wd;
        @(negedge clk);
        p = allowed(a, m);
        check({req, " fwd_valid"}, W'(fwd_valid), W'(v && p));
        if (v && p) check({req, " fwd_addr R1"}, W'(fwd_addr), W'(a));
        check({req, " acc_err R4/R5"}, W'(acc_err), W'(exp_err));
        check({req, " cfg_rdata R6"}, cfg_rdata, model[sel]);
        @(posedge clk);
        exp_err = v && !p;
        if (wr && pr) model[sel] = wd;
        #1;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        model[0] = '0; model[1] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R9: registers clear, every access denied
        for (int q = 0; q < 4; q++)
            cycle(1'b1, qaddr(q, 10'h3F), 4'(q * 5), 1'b0, 1'b0, q[1], '0, "R9 reset");
        // R2/R7: privileged writes of the worked masks
        cycle(1'b0, '0, '0, 1'b1, 1'b1, 1'b0, 32'hCCCC_AAAA, "R7 write bank0");
        cycle(1'b0, '0, '0, 1'b1, 1'b1, 1'b1, 32'h0F0F_8001, "R2 write bank1");
        // R1/R3: every master on every quadrant, varying low address bits
        for (int q = 0; q < 4; q++)
            for (int m = 0; m < 16; m++)
                cycle(1'b1, qaddr(q, 10'(m * 37)), 4'(m), 1'b0, 1'b0, q[1], '0, "R1 R3 sweep");
        // R8: user writes are ignored and raise no error
        cycle(1'b0, '0, '0, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF, "R8 user write");
        cycle(1'b1, qaddr(0, 10'h0), 4'd0, 1'b1, 1'b0, 1'b1, 32'h0, "R8 user write 2");
        cycle(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, '0, "R8 readback0");
        cycle(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, '0, "R8 readback1");
        // R7: access in the cycle of a write uses the old mask
        cycle(1'b1, qaddr(0, 10'h5), 4'd0, 1'b1, 1'b1, 1'b0, 32'h0000_0001, "R7 same cycle");
        cycle(1'b1, qaddr(0, 10'h5), 4'd0, 1'b1, 1'b1, 1'b0, 32'h0000_0000, "R7 after");
        cycle(1'b1, qaddr(0, 10'h5), 4'd0, 1'b0, 1'b0, 1'b0, '0, "R7 cleared");
        cycle(1'b1, qaddr(0, 10'h5), 4'd0, 1'b0, 1'b0, 1'b0, '0, "R4 back-to-back deny");
        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            logic v = ($urandom % 4) != 0;
            logic wr = ($urandom % 6) == 0;
            cycle(v, ADDR_W'($urandom), MID_W'($urandom), wr, 1'($urandom),
                  1'($urandom), $urandom, "R1 R4 R5 R6 R7 R8 random");
        end
        cycle(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, '0, "R5 final idle");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule